// File: doc/BRIEF.md
# Block Move and Block Compare Step Engine

This engine carries out block-move and block-search operations one byte at a time against a synchronous memory port. A caller loads a source pointer, a destination pointer, a 16-bit byte count, the accumulator value and the current flag byte, and then pulses `start`. Each step reads one byte at the source pointer. In move mode the byte is written to the destination pointer. In search mode the byte is compared against the accumulator and nothing is written. After each step the engine adjusts the pointers, decrements the count and rebuilds the flag byte, including the two undocumented copy bits.

With `repeat_en` clear, exactly one step runs. With `repeat_en` set, the engine keeps stepping until the count reaches zero. In search mode it also stops as soon as a byte equals the accumulator. When it stops, the engine presents the final pointers, count and flags, and it pulses `done` for one cycle. A count of zero at start is treated as a full 65536-byte block.

Top module: `blkx_engine`

## Requirements
- R1: While reset is held and after reset, `busy`, `done`, `mem_rd` and `mem_wr` are low.
- R2: Each step drives `mem_rd` with `mem_addr` equal to the source pointer. In move mode, the next cycle drives `mem_wr` with the returned byte to the destination pointer. Search mode never writes. `mem_rd` and `mem_wr` are never high together.
- R3: With `dir_down` low, each step adds 1 to the source pointer, and also to the destination pointer in move mode. With `dir_down` high, each step subtracts 1 instead. In search mode the destination pointer does not change.
- R4: Each step decrements the count by one, and a count of 0 wraps to FFFFh.
- R5: Flag bit 2 is set after a step when the decremented count is nonzero, and cleared when it is zero.
- R6: In move mode, flag bit 4 and flag bit 1 are cleared, and bits 7, 6 and 0 keep their loaded values. Bit 5 is bit 1 of (byte + accumulator), and bit 3 is bit 3 of that sum.
- R7: In search mode, D is accumulator minus byte. Bit 7 is D[7], bit 6 is set when D is zero, and bit 4 is the borrow out of the low nibble. Bit 1 is set and bit 0 keeps its loaded value. With that new bit 4 as H, bit 5 is bit 1 of (D − H) and bit 3 is bit 3 of (D − H).
- R8: Without `repeat_en`, exactly one step runs. With it, steps continue while the decremented count is nonzero.
- R9: In search mode with `repeat_en`, the engine stops after the first step that sets bit 6, even when the count is still nonzero.
- R10: `done` is high for exactly one cycle, 2·N+1 cycles after the edge that samples `start`, for N steps. `busy` is high from the cycle after `start` until that cycle.
- R11: `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| cmp_mode | input | 1 | 0 move, 1 search |
| dir_down | input | 1 | 0 increment pointers, 1 decrement |
| repeat_en | input | 1 | Iterate until count zero or match |
| src_init | input | 16 | Initial source pointer |
| dst_init | input | 16 | Initial destination pointer |
| cnt_init | input | 16 | Initial byte count |
| acc_in | input | 8 | Accumulator value |
| flags_in | input | 8 | Flag byte before the operation |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read request, data valid next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flags_out | output | 8 | Current flag byte |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count | output | 16 | Current byte count |

## Verification
In a repeated search, the match stop and the count-exhausted stop can fall on the same step. The bench provokes this by placing the matching byte at the last counted position. It then judges that exactly one `done` pulse arrives at the cycle predicted for that step count, with bit 6 set, bit 2 clear and the count at zero. An early-match run and a no-match run bracket this case. In those runs the two stop conditions occur separately, and each must leave the expected count and pointer.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2
  } blkx_state_t;

  localparam int FB_SIGN  = 7;
  localparam int FB_ZERO  = 6;
  localparam int FB_CPY5  = 5;
  localparam int FB_HALF  = 4;
  localparam int FB_CPY3  = 3;
  localparam int FB_PV    = 2;
  localparam int FB_SUB   = 1;
  localparam int FB_CARRY = 0;
endpackage

// File: rtl/blkx_rst_sync.sv
module blkx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/blkx_flag_calc.sv
module blkx_flag_calc
  import blkx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          cmp,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mdata,
  input  logic [7:0]    flags_cur,
  input  logic          cnt_nz,
  output logic [7:0]    flags_nxt,
  output logic          z_new
);
  localparam int NIB = 4;

  logic [DW-1:0] sum;
  logic [DW-1:0] diff;
  logic [DW-1:0] diff_h;
  logic          half_borrow;

  always_comb begin
    sum         = mdata + acc;
    diff        = acc - mdata;
    half_borrow = (acc[NIB-1:0] < mdata[NIB-1:0]);
    diff_h      = diff - {{(DW-1){1'b0}}, half_borrow};
    z_new       = (diff == '0);
  end

  always_comb begin
    flags_nxt = flags_cur;
    if (cmp) begin
      flags_nxt[FB_SIGN] = diff[DW-1];
      flags_nxt[FB_ZERO] = z_new;
      flags_nxt[FB_HALF] = half_borrow;
      flags_nxt[FB_CPY5] = |(diff_h & DW'(2));
      flags_nxt[FB_CPY3] = |(diff_h & DW'(8));
      flags_nxt[FB_SUB]  = 1'b1;
    end else begin
      flags_nxt[FB_HALF] = 1'b0;
      flags_nxt[FB_SUB]  = 1'b0;
      flags_nxt[FB_CPY5] = |(sum & DW'(2));
      flags_nxt[FB_CPY3] = |(sum & DW'(8));
    end
    flags_nxt[FB_PV] = cnt_nz;
  end
endmodule

// File: rtl/blkx_addr_unit.sv
module blkx_addr_unit #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          dir_dn,
  input  logic          move_dst,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          cnt_after_nz
);
  logic [AW-1:0] src_d, dst_d, src_adj, dst_adj;
  logic [CW-1:0] cnt_d, cnt_dec;

  always_comb begin
    cnt_dec      = cnt - 1'b1;
    cnt_after_nz = (cnt_dec != '0);
    src_adj      = dir_dn ? (src - 1'b1) : (src + 1'b1);
    dst_adj      = dir_dn ? (dst - 1'b1) : (dst + 1'b1);
  end

  always_comb begin
    src_d = src;
    dst_d = dst;
    cnt_d = cnt;
    if (load) begin
      src_d = src_init;
      dst_d = dst_init;
      cnt_d = cnt_init;
    end else if (step) begin
      src_d = src_adj;
      if (move_dst) dst_d = dst_adj;
      cnt_d = cnt_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
    end else if (load || step) begin
      src <= src_d;
      dst <= dst_d;
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rpt,
  input  logic cmp,
  input  logic cnt_after_nz,
  input  logic z_new,
  output logic load,
  output logic rd,
  output logic ex,
  output logic busy,
  output logic done
);
  blkx_state_t state_q, state_d;
  logic        done_d;
  logic        go_on;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    rd      = 1'b0;
    ex      = 1'b0;
    done_d  = 1'b0;
    go_on   = rpt && cnt_after_nz && !(cmp && z_new);
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        rd      = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        ex = 1'b1;
        if (go_on) begin
          state_d = ST_READ;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/blkx_engine.sv
module blkx_engine #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int CW         = 16,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_mode,
  input  logic          dir_down,
  input  logic          repeat_en,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  input  logic [DW-1:0] acc_in,
  input  logic [7:0]    flags_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    flags_out,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count
);
  logic          rst_i_n;
  logic          load, rd, ex;
  logic          cnt_after_nz, z_new;
  logic          op_q, dir_q, rpt_q;
  logic [DW-1:0] acc_q;
  logic [7:0]    flags_q, flags_nxt;

  blkx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  blkx_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .rpt(rpt_q), .cmp(op_q),
    .cnt_after_nz(cnt_after_nz), .z_new(z_new),
    .load(load), .rd(rd), .ex(ex), .busy(busy), .done(done)
  );

  blkx_addr_unit #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst_n(rst_i_n), .load(load), .step(ex), .dir_dn(dir_q),
    .move_dst(!op_q), .src_init(src_init), .dst_init(dst_init),
    .cnt_init(cnt_init), .src(src_ptr), .dst(dst_ptr), .cnt(count),
    .cnt_after_nz(cnt_after_nz)
  );

  blkx_flag_calc #(.DW(DW)) u_flag (
    .cmp(op_q), .acc(acc_q), .mdata(mem_rdata), .flags_cur(flags_q),
    .cnt_nz(cnt_after_nz), .flags_nxt(flags_nxt), .z_new(z_new)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      op_q  <= 1'b0;
      dir_q <= 1'b0;
      rpt_q <= 1'b0;
      acc_q <= '0;
    end else if (load) begin
      op_q  <= cmp_mode;
      dir_q <= dir_down;
      rpt_q <= repeat_en;
      acc_q <= acc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)  flags_q <= '0;
    else if (load) flags_q <= flags_in;
    else if (ex)   flags_q <= flags_nxt;
  end

  always_comb begin
    mem_rd    = rd;
    mem_wr    = ex && !op_q;
    mem_addr  = mem_wr ? dst_ptr : src_ptr;
    mem_wdata = mem_rdata;
    flags_out = flags_q;
  end
endmodule

// File: rtl/blkx_checker.sv
module blkx_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          busy,
  input logic          done,
  input logic          op_cmp,
  input logic [7:0]    flags_out,
  input logic [CW-1:0] count
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R2
  AST_WR_MOVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !op_cmp); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> count == CW'($past(count) - 1'b1)); // R4
  AST_PV_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flags_out[2] == (count != '0)); // R5
  AST_SUB_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_cmp) |-> flags_out[1]); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

bind blkx_engine blkx_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy),
  .done(done), .op_cmp(op_q), .flags_out(flags_out), .count(count)
);

// File: tb/tb_blkx_engine.sv
module tb_blkx_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, cmp_mode, dir_down, repeat_en;
  logic [15:0] src_init, dst_init, cnt_init;
  logic [7:0]  acc_in, flags_in;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done;
  logic [7:0]  flags_out;
  logic [15:0] src_ptr, dst_ptr, count;

  int checks = 0;
  int errors = 0;

  logic [7:0]  mem [0:65535];
  logic [15:0] ew_addr [0:15];
  logic [7:0]  ew_data [0:15];
  int          ew_n;

  always #2 clk = ~clk;

  blkx_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_mode(cmp_mode),
    .dir_down(dir_down), .repeat_en(repeat_en), .src_init(src_init),
    .dst_init(dst_init), .cnt_init(cnt_init), .acc_in(acc_in),
    .flags_in(flags_in), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .flags_out(flags_out), .src_ptr(src_ptr),
    .dst_ptr(dst_ptr), .count(count)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Flag model taken from R5, R6, R7
  function automatic logic [7:0] step_flags(input bit cmp, input logic [7:0] a,
      input logic [7:0] m, input logic [7:0] f, input bit nz);
    logic [7:0] r, s, d, n;
    logic       h;
    r = f;
    if (!cmp) begin
      s = m + a;
      r[5] = s[1]; r[3] = s[3]; r[4] = 1'b0; r[1] = 1'b0;
    end else begin
      d = a - m;
      h = (a[3:0] < m[3:0]);
      n = d - {7'd0, h};
      r[7] = d[7]; r[6] = (d == 8'd0); r[4] = h;
      r[5] = n[1]; r[3] = n[3]; r[1] = 1'b1;
    end
    r[2] = nz;
    return r;
  endfunction

  task automatic run_op(input string tag, input bit cmp, input bit dn,
      input bit rpt, input logic [15:0] s, input logic [15:0] d,
      input logic [15:0] c, input logic [7:0] a, input logic [7:0] f,
      input bit poke);
    logic [15:0] es, ed, ec;
    logic [7:0]  ef, m;
    int          steps, cyc, dones, done_cyc;
    bit          stop;
    es = s; ed = d; ec = c; ef = f; steps = 0; ew_n = 0;
    do begin
      m  = mem[es];
      ec = ec - 16'd1;
      ef = step_flags(cmp, a, m, ef, ec != 16'd0);
      if (!cmp) begin
        ew_addr[ew_n] = ed; ew_data[ew_n] = m; ew_n++;
        ed = dn ? ed - 16'd1 : ed + 16'd1;
      end
      es = dn ? es - 16'd1 : es + 16'd1;
      steps++;
      stop = !rpt || (ec == 16'd0) || (cmp && ef[6]);
    end while (!stop && steps < 16);

    @(negedge clk);
    start = 1'b1; cmp_mode = cmp; dir_down = dn; repeat_en = rpt;
    src_init = s; dst_init = d; cnt_init = c; acc_in = a; flags_in = f;
    @(negedge clk);
    start = 1'b0;
    src_init = 16'hDEAD; dst_init = 16'hBEEF; cnt_init = 16'h0001;
    cmp_mode = ~cmp; repeat_en = 1'b0;
    chk({tag, " R10 busy after start"}, busy, 1);
    cyc = 1; dones = 0; done_cyc = 0;
    while (cyc < 80) begin
      if (poke && cyc == 2) start = 1'b1;  // R11 start while busy
      if (poke && cyc == 3) start = 1'b0;
      @(negedge clk);
      cyc++;
      if (done) begin
        dones++;
        if (done_cyc == 0) done_cyc = cyc;
      end
      if (done_cyc != 0 && cyc > done_cyc + 1) break;
    end
    start = 1'b0;
    chk({tag, " R10 done count"}, dones, 1);
    chk({tag, " R10 done timing"}, done_cyc, 2 * steps + 1);
    chk({tag, " R10 idle after done"}, busy, 0);
    chk({tag, " R3 src"}, src_ptr, es);
    chk({tag, " R3 dst"}, dst_ptr, ed);
    chk({tag, " R4 count"}, count, ec);
    chk({tag, cmp ? " R7 flags" : " R6 flags"}, flags_out, ef);
    chk({tag, " R5 pv"}, flags_out[2], ec != 16'd0);
    for (int i = 0; i < ew_n; i++)
      chk({tag, " R2 written byte"}, mem[ew_addr[i]], ew_data[i]);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 mem_rd", mem_rd, 0);
    chk("R1 mem_wr", mem_wr, 0);
  endtask

  task automatic t_move_single();
    mem[16'h0100] = 8'h3A;
    mem[16'h0200] = 8'h00;
    // 3A+05=3F: bits 1 and 3 set; S,Z,C kept at 1; H,N cleared; PV=1
    run_op("move1", 0, 0, 0, 16'h0100, 16'h0200, 16'd3, 8'h05, 8'hFF, 0);
    chk("R6 literal flags", flags_out, 8'hED);
    chk("R8 single step count", count, 16'd2);
  endtask

  task automatic t_move_repeat_down();
    for (int i = 0; i < 4; i++) mem[16'h0310 - i] = 8'h90 + 8'(i * 7);
    run_op("moverpt", 0, 1, 1, 16'h0310, 16'h0410, 16'd4, 8'h21, 8'h00, 0);
    chk("R8 repeat ran to zero", count, 16'd0);
    chk("R3 down dst", dst_ptr, 16'h040C);
  endtask

  task automatic t_wrap();
    mem[16'h0700] = 8'h5C;
    run_op("wrap", 0, 0, 0, 16'h0700, 16'h0800, 16'd0, 8'h9E, 8'h41, 0);
    chk("R4 wrap count", count, 16'hFFFF);
    chk("R5 wrap pv", flags_out[2], 1);
  endtask

  task automatic t_cmp_single();
    mem[16'h0900] = 8'h15;
    run_op("cmp1", 1, 0, 0, 16'h0900, 16'h0A00, 16'd2, 8'h20, 8'h01, 0);
    chk("R3 search dst fixed", dst_ptr, 16'h0A00);
    chk("R7 carry kept", flags_out[0], 1);
  endtask

  task automatic t_cmp_early();
    mem[16'h0500] = 8'h11; mem[16'h0501] = 8'h22;
    mem[16'h0502] = 8'h33; mem[16'h0503] = 8'h44;
    run_op("cmpearly", 1, 0, 1, 16'h0500, 16'h0600, 16'd10, 8'h33, 8'h00, 0);
    chk("R9 early stop count", count, 16'd7);
    chk("R9 zero set", flags_out[6], 1);
  endtask

  task automatic t_cmp_both();
    mem[16'h0B00] = 8'h01; mem[16'h0B01] = 8'h02; mem[16'h0B02] = 8'h77;
    run_op("cmpboth", 1, 0, 1, 16'h0B00, 16'h0C00, 16'd3, 8'h77, 8'h80, 0);
    chk("R9 match and zero count", {flags_out[6], flags_out[2]}, 2'b10);
    chk("R8 count zero", count, 16'd0);
  endtask

  task automatic t_cmp_nomatch_down();
    for (int i = 0; i < 5; i++) mem[16'h0D20 - i] = 8'h40 + 8'(i);
    run_op("cmpnone", 1, 1, 1, 16'h0D20, 16'h0E00, 16'd5, 8'h0F, 8'h00, 0);
    chk("R8 full run src", src_ptr, 16'h0D1B);
    chk("R9 no match", flags_out[6], 0);
  endtask

  task automatic t_start_busy();
    for (int i = 0; i < 3; i++) mem[16'h1000 + i] = 8'hA0 + 8'(i);
    run_op("busystart", 0, 0, 1, 16'h1000, 16'h1100, 16'd3, 8'h0C, 8'h00, 1);
    chk("R11 ignored start kept src", src_ptr, 16'h1003);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cmp_mode = 1'b0; dir_down = 1'b0;
    repeat_en = 1'b0; src_init = '0; dst_init = '0; cnt_init = '0;
    acc_in = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_move_single();
    t_move_repeat_down();
    t_wrap();
    t_cmp_single();
    t_cmp_early();
    t_cmp_both();
    t_cmp_nomatch_down();
    t_start_busy();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule